// File: doc/BRIEF.md
# Register Command List Executor

This block walks a list of 32-bit command words held in a local command RAM and turns each command into accesses on a simple register bus. Software writes a list into the RAM, then asks the engine to run it by naming a queue (high or low priority), a context slot, a word offset inside that slot's segment and a length in words. The engine reads the words one at a time. It decodes the opcode in each header word and fetches that command's operand words. It then performs plain register writes, masked read-modify-writes, or burst writes to one fixed register or to a run of ascending registers.

The command RAM is divided into equal segments, one per context and queue. The high-priority queue owns the first group of segments and the low-priority queue owns the group after it. A busy flag covers the whole job. When the list is exhausted, the engine raises one or both of two sticky completion interrupt bits, chosen by a two-bit field given with the start request. Software alternates that field between successive jobs and clears the bits by writing ones.

Top module: `cmdlist_exec`

## Requirements
- R1: After reset `busy` and `irq_status` are 0, and none of `ram_rd_en`, `reg_wr_en` or `reg_rd_en` is asserted.
- R2: A header word holds the opcode in bits [31:28] and a byte offset in bits [19:0]. Bits [27:20] are ignored. The target address is `REG_BASE` plus the offset. Opcode 1 (write) takes one data word and writes it to the target.
- R3: Opcode 0 (no-op) consumes only its header word and causes no register access.
- R4: Opcode 2 (modify) takes a mask word and then a data word. It reads the target and writes `(old & mask) | data` back to the same address.
- R5: Opcode 3 (fixed burst) takes a count word N and then N data words, all written to the same target address. N = 0 writes nothing.
- R6: Opcode 4 (ascending burst) has the same layout as opcode 3, but the target address rises by 4 after each data word.
- R7: Opcodes 5 to 15 consume one word with no register access, and execution carries on at the next word.
- R8: Execution begins at word `(queue*NCTX + ctx)*SEG_WORDS + offset`, with queue 0 = high priority and queue 1 = low priority. A new header is fetched only while the read pointer is below start plus length. A length of 0 completes with no register access.
- R9: `busy` rises on an accepted start and falls when the job completes. A start request while `busy` is 1 is ignored.
- R10: On completion, `irq_status` is ORed with the two-bit select given at start (value 1 sets bit 0, value 2 sets bit 1). The bits stay set until a 1 is written to the matching `irq_clr` bit. A set in the same cycle as a clear wins.
- R11: The write of a modify follows its read in the very next cycle at the same address. A read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Start request strobe |
| start_queue | input | 1 | 0 = high-priority queue, 1 = low-priority queue |
| start_ctx | input | CTX_W | Context slot within the queue |
| start_off | input | OFF_W | Word offset inside the segment |
| start_len | input | LEN_W | List length in words |
| start_irq_sel | input | 2 | Completion interrupt bits to set |
| irq_clr | input | 2 | Write-one-to-clear for `irq_status` |
| busy | output | 1 | Job in progress |
| irq_status | output | 2 | Sticky completion interrupt bits |
| ram_rd_en | output | 1 | Command RAM read strobe |
| ram_rd_addr | output | AW | Command RAM word address |
| ram_rd_data | input | 32 | Command RAM read data, valid one cycle after the strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | 32 | Register byte address |
| reg_wdata | output | 32 | Register write data |
| reg_rd_data | input | 32 | Register read data, valid one cycle after the read strobe |

## Verification
The bench uses the defaults: 32-word segments, two contexts per queue (a 128-word RAM) and `REG_BASE` 0x4000_0000. With these values every segment of both queues, offsets near a segment end and full 32-word lists are all cheap to reach. Words outside the active list are filled with a write command aimed at a sentinel register, so a wrong segment base or a read past the end shows up in the register image. The register offsets stay below 256 bytes, so an ascending burst can be checked word by word against a 64-entry register model.

// File: rtl/cmdx_pkg.sv
// Shared encodings for the command list executor.
// Assumes 32-bit command words with the opcode in the top nibble.
package cmdx_pkg;
    localparam int WORD_W = 32;
    localparam int OFFS_W = 20;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_WRITE  = 4'd1,
        OP_MODIFY = 4'd2,
        OP_BFIX   = 4'd3,
        OP_BINC   = 4'd4
    } opcode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHK,
        S_RD,
        S_WAIT,
        S_MWAIT
    } walk_state_e;

    typedef enum logic [2:0] {
        P_HDR,
        P_WDATA,
        P_MASK,
        P_MDATA,
        P_CNT,
        P_BDATA
    } walk_phase_e;
endpackage

// File: rtl/cmdx_seg_map.sv
// Segment address map: turns (queue, context, offset, length) into the
// first and end word pointers of a job. Assumes the high-priority queue owns
// the first NCTX segments and the low-priority queue the next NCTX.
module cmdx_seg_map #(
    parameter int SEG_WORDS = 32,
    parameter int NCTX      = 2,
    parameter int CTX_W     = 1,
    parameter int OFF_W     = 5,
    parameter int LEN_W     = 6,
    parameter int PW        = 8
) (
    input  logic             queue,
    input  logic [CTX_W-1:0] ctx,
    input  logic [OFF_W-1:0] off,
    input  logic [LEN_W-1:0] len,
    output logic [PW-1:0]    first_ptr,
    output logic [PW-1:0]    end_ptr
);
    logic [31:0] slot;
    logic [31:0] first_w;

    // Segment index and start word of the job.
    always_comb begin
        slot    = (queue ? 32'(NCTX) : 32'd0) + 32'(ctx);
        first_w = slot * 32'(SEG_WORDS) + 32'(off);
    end

    assign first_ptr = PW'(first_w);
    assign end_ptr   = PW'(first_w + 32'(len));
endmodule

// File: rtl/cmdx_ctrl.sv
// Job control: accepts a start when idle, holds busy until the walker
// reports completion, and keeps the sticky completion interrupt bits.
// Assumes done only pulses while busy.
module cmdx_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_valid,
    input  logic [1:0] start_irq_sel,
    input  logic [1:0] irq_clr,
    input  logic       done,
    output logic       go,
    output logic       busy,
    output logic [1:0] irq_status
);
    logic [1:0] sel_q;

    assign go = start_valid && !busy;

    // Busy flag and the latched interrupt select of the running job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sel_q <= 2'b00;
        end else if (go) begin
            busy  <= 1'b1;
            sel_q <= start_irq_sel;
        end else if (done) begin
            busy  <= 1'b0;
        end
    end

    // Sticky interrupt bits: write-one-to-clear, a completion set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_status <= 2'b00;
        else        irq_status <= (irq_status & ~irq_clr) | (done ? sel_q : 2'b00);
    end

    // R9: a running job keeps busy until its completion
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R9: a start seen while busy leaves the running job's select alone
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_valid) |=> $stable(sel_q));
    // R10: set bits stay until cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[0] && !irq_clr[0]) |=> irq_status[0]);
    // R10: completion raises the selected bit even if a clear is present
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sel_q[1]) |=> irq_status[1]);
endmodule

// File: rtl/cmdx_walker.sv
// Command walker: reads words from the command RAM (one-cycle read
// latency), decodes headers and issues register bus accesses. Each word
// costs an issue cycle and a data cycle. Assumes register read data arrives
// one cycle after reg_rd_en.
module cmdx_walker
    import cmdx_pkg::*;
#(
    parameter int          AW       = 7,
    parameter int          PW       = 8,
    parameter logic [31:0] REG_BASE = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [PW-1:0]     first_ptr,
    input  logic [PW-1:0]     end_ptr,
    output logic              done,
    output logic              ram_rd_en,
    output logic [AW-1:0]     ram_rd_addr,
    input  logic [WORD_W-1:0] ram_rd_data,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [31:0]       reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rd_data
);
    walk_state_e       state;
    walk_phase_e       phase;
    logic [PW-1:0]     ptr;
    logic [PW-1:0]     endp;
    logic [31:0]       tgt;
    logic              inc_q;
    logic [WORD_W-1:0] mask_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] cnt_q;
    logic              more;
    logic [3:0]        hdr_op;
    logic [OFFS_W-1:0] hdr_off;

    assign more        = (ptr < endp);
    assign hdr_op      = ram_rd_data[31:28];
    assign hdr_off     = ram_rd_data[OFFS_W-1:0];
    assign ram_rd_addr = ptr[AW-1:0];
    assign reg_addr    = tgt;

    // Strobes and write data from the current state and phase.
    always_comb begin
        done      = 1'b0;
        ram_rd_en = 1'b0;
        reg_wr_en = 1'b0;
        reg_rd_en = 1'b0;
        reg_wdata = ram_rd_data;
        case (state)
            S_CHK: begin
                ram_rd_en = more;
                done      = !more;
            end
            S_RD:  ram_rd_en = 1'b1;
            S_WAIT: begin
                case (phase)
                    P_WDATA, P_BDATA: reg_wr_en = 1'b1;
                    P_MDATA:          reg_rd_en = 1'b1;
                    default:          ;
                endcase
            end
            S_MWAIT: begin
                reg_wr_en = 1'b1;
                reg_wdata = (reg_rd_data & mask_q) | data_q;
            end
            default: ;
        endcase
    end

    // Sequencer: pointer, phase and operand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            phase  <= P_HDR;
            ptr    <= '0;
            endp   <= '0;
            tgt    <= '0;
            inc_q  <= 1'b0;
            mask_q <= '0;
            data_q <= '0;
            cnt_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (go) begin
                    ptr   <= first_ptr;
                    endp  <= end_ptr;
                    state <= S_CHK;
                end
                S_CHK: begin
                    if (more) begin
                        ptr   <= ptr + 1'b1;
                        phase <= P_HDR;
                        state <= S_WAIT;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_RD: begin
                    ptr   <= ptr + 1'b1;
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    case (phase)
                        P_HDR: begin
                            tgt <= REG_BASE + {{(32-OFFS_W){1'b0}}, hdr_off};
                            case (hdr_op)
                                OP_WRITE:  begin phase <= P_WDATA; state <= S_RD; end
                                OP_MODIFY: begin phase <= P_MASK;  state <= S_RD; end
                                OP_BFIX:   begin inc_q <= 1'b0; phase <= P_CNT; state <= S_RD; end
                                OP_BINC:   begin inc_q <= 1'b1; phase <= P_CNT; state <= S_RD; end
                                default:   state <= S_CHK;
                            endcase
                        end
                        P_WDATA: state <= S_CHK;
                        P_MASK: begin
                            mask_q <= ram_rd_data;
                            phase  <= P_MDATA;
                            state  <= S_RD;
                        end
                        P_MDATA: begin
                            data_q <= ram_rd_data;
                            state  <= S_MWAIT;
                        end
                        P_CNT: begin
                            cnt_q <= ram_rd_data;
                            if (ram_rd_data == '0) begin
                                state <= S_CHK;
                            end else begin
                                phase <= P_BDATA;
                                state <= S_RD;
                            end
                        end
                        P_BDATA: begin
                            if (inc_q) tgt <= tgt + 32'd4;
                            cnt_q <= cnt_q - 1'b1;
                            state <= (cnt_q == 32'd1) ? S_CHK : S_RD;
                        end
                        default: state <= S_CHK;
                    endcase
                end
                S_MWAIT: state <= S_CHK;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: a modify read is followed next cycle by its write to the same address
    a_r11_rmw_pair: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> (reg_wr_en && $stable(reg_addr)));
    // R11: never a read and a write together
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en && reg_wr_en));
    // R3: header decode cycles make no register access
    a_r3_hdr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && phase == P_HDR) |-> (!reg_wr_en && !reg_rd_en));
    // R5: a fixed burst keeps its target address
    a_r5_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && phase == P_BDATA && !inc_q) |=> $stable(reg_addr));
    // R8: completion is never reported together with a fetch
    a_r8_done_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ram_rd_en);
endmodule

// File: rtl/cmdlist_exec.sv
// Top of the command list executor: segment map, job control and walker.
// Assumes an external command RAM and register target, each with a
// one-cycle read latency.
module cmdlist_exec #(
    parameter int          SEG_WORDS = 32,
    parameter int          NCTX      = 2,
    parameter logic [31:0] REG_BASE  = 32'h4000_0000,
    localparam int         CTX_W     = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int         OFF_W     = $clog2(SEG_WORDS),
    localparam int         LEN_W     = OFF_W + 1,
    localparam int         AW        = $clog2(SEG_WORDS * NCTX * 2),
    localparam int         PW        = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    input  logic             start_queue,
    input  logic [CTX_W-1:0] start_ctx,
    input  logic [OFF_W-1:0] start_off,
    input  logic [LEN_W-1:0] start_len,
    input  logic [1:0]       start_irq_sel,
    input  logic [1:0]       irq_clr,
    output logic             busy,
    output logic [1:0]       irq_status,
    output logic             ram_rd_en,
    output logic [AW-1:0]    ram_rd_addr,
    input  logic [31:0]      ram_rd_data,
    output logic             reg_wr_en,
    output logic             reg_rd_en,
    output logic [31:0]      reg_addr,
    output logic [31:0]      reg_wdata,
    input  logic [31:0]      reg_rd_data
);
    logic          go;
    logic          done;
    logic [PW-1:0] first_ptr;
    logic [PW-1:0] end_ptr;

    cmdx_seg_map #(
        .SEG_WORDS(SEG_WORDS), .NCTX(NCTX), .CTX_W(CTX_W),
        .OFF_W(OFF_W), .LEN_W(LEN_W), .PW(PW)
    ) map_i (
        .queue(start_queue), .ctx(start_ctx), .off(start_off), .len(start_len),
        .first_ptr(first_ptr), .end_ptr(end_ptr)
    );

    cmdx_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
        .start_irq_sel(start_irq_sel), .irq_clr(irq_clr), .done(done),
        .go(go), .busy(busy), .irq_status(irq_status)
    );

    cmdx_walker #(.AW(AW), .PW(PW), .REG_BASE(REG_BASE)) walk_i (
        .clk(clk), .rst_n(rst_n), .go(go),
        .first_ptr(first_ptr), .end_ptr(end_ptr), .done(done),
        .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data)
    );

    // R1/R8: an idle engine touches neither the RAM nor the register bus
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ram_rd_en && !reg_wr_en && !reg_rd_en));
    // R9: completion drops busy on the next cycle
    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy);
endmodule

// File: tb/cmdlist_exec_tb_top.sv
module cmdlist_exec_tb_top;
    localparam int SEGW   = 32;
    localparam int NC     = 2;
    localparam int RAMW   = SEGW * NC * 2;
    localparam logic [31:0] SENT = 32'h1000_00FC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_queue = 1'b0;
    logic [0:0]  start_ctx = '0;
    logic [4:0]  start_off = '0;
    logic [5:0]  start_len = '0;
    logic [1:0]  start_irq_sel = '0;
    logic [1:0]  irq_clr = '0;
    logic        busy;
    logic [1:0]  irq_status;
    logic        ram_rd_en;
    logic [6:0]  ram_rd_addr;
    logic [31:0] ram_rd_data;
    logic        reg_wr_en, reg_rd_en;
    logic [31:0] reg_addr, reg_wdata, reg_rd_data;

    logic [31:0] ram [RAMW];
    logic [31:0] regs [64];
    logic [31:0] exp_regs [64];
    logic [31:0] lst [SEGW];
    int          lst_n;
    logic [1:0]  exp_irq;
    int          n_checks = 0, n_fail = 0, wr_cnt = 0, cyc = 0;
    logic        prev_rd = 1'b0;
    logic [31:0] prev_addr = '0;

    always #2.5 clk = ~clk;

    cmdlist_exec dut_i (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_queue(start_queue),
        .start_ctx(start_ctx), .start_off(start_off), .start_len(start_len),
        .start_irq_sel(start_irq_sel), .irq_clr(irq_clr), .busy(busy),
        .irq_status(irq_status), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
        .ram_rd_data(ram_rd_data), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data)
    );

    function automatic logic [31:0] init_val(int i);
        return 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101);
    endfunction

    // Command RAM model, one-cycle read latency.
    always @(posedge clk) if (ram_rd_en) ram_rd_data <= ram[ram_rd_addr];

    // Register target model, one-cycle read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) regs[i] <= init_val(i);
            reg_rd_data <= '0;
        end else begin
            if (reg_wr_en) regs[reg_addr[7:2]] <= reg_wdata;
            if (reg_rd_en) reg_rd_data <= regs[reg_addr[7:2]];
        end
    end

    task automatic report_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            report_end();
        end
    end

    // Bus monitor: write count, R11 pairing, R2 address base.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_en) wr_cnt++;
            if (prev_rd) check(reg_wr_en && reg_addr == prev_addr, "R11 rmw write", reg_addr, prev_addr);
            if (reg_rd_en && reg_wr_en) check(1'b0, "R11 overlap", 32'd1, 32'd0);
            if (reg_wr_en && reg_addr[31:8] != 24'h400000) check(1'b0, "R2 base", reg_addr, 32'h4000_0000);
            prev_rd   = reg_rd_en;
            prev_addr = reg_addr;
        end
    end

    function automatic logic [31:0] hdr(int op, int idx);
        return {4'(op), 8'($urandom), 12'd0, 6'(idx), 2'b00};
    endfunction

    function automatic int seg_first(int q, int c, int off);
        return (q * NC + c) * SEGW + off;
    endfunction

    // Reference interpreter over the bench's RAM image; returns write count.
    function automatic int model(int first, int len);
        int p = first, e = first + len, wc = 0;
        while (p < e) begin
            logic [31:0] h = ram[p];
            int idx = int'(h[7:2]);
            p++;
            case (int'(h[31:28]))
                1: begin exp_regs[idx] = ram[p]; p++; wc++; end
                2: begin exp_regs[idx] = (exp_regs[idx] & ram[p]) | ram[p+1]; p += 2; wc++; end
                3, 4: begin
                    int n = int'(ram[p]);
                    p++;
                    for (int k = 0; k < n; k++) begin
                        exp_regs[idx] = ram[p]; p++; wc++;
                        if (h[31:28] == 4'd4) idx++;
                    end
                end
                default: ;
            endcase
        end
        return wc;
    endfunction

    task automatic place(int first);
        for (int i = 0; i < RAMW; i++) ram[i] = SENT;
        for (int i = 0; i < lst_n; i++) ram[first + i] = lst[i];
    endtask

    task automatic push(logic [31:0] w);
        lst[lst_n] = w;
        lst_n++;
    endtask

    task automatic drive_start(int q, int c, int off, int len, int sel);
        start_valid   = 1'b1;
        start_queue   = 1'(q);
        start_ctx     = 1'(c);
        start_off     = 5'(off);
        start_len     = 6'(len);
        start_irq_sel = 2'(sel);
    endtask

    task automatic wait_idle(string req);
        int t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        check(!busy, req, 32'(busy), 32'd0);
    endtask

    task automatic check_regs(string req);
        int bad = 0, first_bad = 0;
        for (int i = 0; i < 64; i++)
            if (regs[i] !== exp_regs[i]) begin
                if (bad == 0) first_bad = i;
                bad++;
            end
        check(bad == 0, req, regs[first_bad], exp_regs[first_bad]);
    endtask

    // Runs the list in lst[] at the given segment position and checks it.
    task automatic run_job(int q, int c, int off, int sel, string req);
        int first = seg_first(q, c, off);
        int ewc;
        place(first);
        ewc = model(first, lst_n);
        wr_cnt = 0;
        @(negedge clk);
        drive_start(q, c, off, lst_n, sel);
        @(negedge clk);
        start_valid = 1'b0;
        check(busy, {req, " busy"}, 32'(busy), 32'd1);
        wait_idle({req, " R9 done"});
        exp_irq = exp_irq | 2'(sel);
        check_regs({req, " regs"});
        check(wr_cnt == ewc, {req, " writes"}, 32'(wr_cnt), 32'(ewc));
        check(irq_status == exp_irq, "R10 irq", 32'(irq_status), 32'(exp_irq));
    endtask

    task automatic clear_irq(logic [1:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = 2'b00;
        exp_irq = exp_irq & ~m;
        check(irq_status == exp_irq, "R10 clear", 32'(irq_status), 32'(exp_irq));
    endtask

    task automatic gen_random(int budget);
        lst_n = 0;
        while (lst_n < budget) begin
            int kind = int'($urandom % 6);
            int room = budget - lst_n;
            int n = int'($urandom % 4);
            int idx = int'($urandom % (63 - n));
            case (kind)
                0: push(hdr(0, idx));
                1: if (room >= 2) begin push(hdr(1, idx)); push($urandom); end
                2: if (room >= 3) begin push(hdr(2, idx)); push($urandom); push($urandom); end
                3, 4: if (room >= 2 + n) begin
                    push(hdr(kind, idx)); push(32'(n));
                    for (int k = 0; k < n; k++) push($urandom);
                end
                default: push(hdr(5 + int'($urandom % 11), idx));
            endcase
            if ($urandom % 8 == 0) break;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        exp_irq = 2'b00;
        for (int i = 0; i < 64; i++) exp_regs[i] = init_val(i);
        for (int i = 0; i < RAMW; i++) ram[i] = SENT;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!busy && irq_status == 2'b00, "R1 reset status", {30'd0, irq_status}, 32'd0);
        check(!ram_rd_en && !reg_wr_en && !reg_rd_en, "R1 strobes", 32'(reg_wr_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: single write with junk in header bits 27:20
        lst_n = 0; push(hdr(1, 5)); push(32'hDEAD_BEEF);
        run_job(0, 0, 0, 1, "R2");
        // R3: no-op list
        lst_n = 0; push(hdr(0, 1)); push(hdr(0, 2)); push(hdr(0, 3));
        run_job(0, 1, 3, 2, "R3");
        clear_irq(2'b11);
        // R7: unknown opcodes then a write
        lst_n = 0; push(hdr(7, 9)); push(hdr(15, 9)); push(hdr(1, 9)); push(32'h0000_7777);
        run_job(1, 0, 10, 1, "R7");
        // R4: modify
        lst_n = 0; push(hdr(2, 12)); push(32'hFFFF_0000); push(32'h0000_1234);
        run_job(1, 1, 29, 2, "R4");
        // R5: fixed burst of 3, then a zero-count burst, then a write
        lst_n = 0; push(hdr(3, 20)); push(32'd3); push(32'h11); push(32'h22); push(32'h33);
        push(hdr(3, 21)); push(32'd0); push(hdr(1, 22)); push(32'h44);
        run_job(0, 0, 7, 1, "R5");
        // R6: ascending burst of 4
        lst_n = 0; push(hdr(4, 30)); push(32'd4);
        for (int k = 0; k < 4; k++) push(32'hC0DE_0000 + 32'(k));
        run_job(1, 1, 0, 2, "R6");
        clear_irq(2'b01);
        // R8: zero length job
        lst_n = 0;
        run_job(0, 1, 31, 1, "R8 empty");
        // R8: list filling a whole segment at the end of the RAM
        gen_random(SEGW - 1);
        run_job(1, 1, 1, 2, "R8 segment");
        clear_irq(2'b11);

        // R9: a start while busy is ignored
        begin
            int fa = seg_first(0, 0, 0);
            int ewc;
            lst_n = 0; push(hdr(4, 40)); push(32'd3); push(32'h1); push(32'h2); push(32'h3);
            place(fa);
            ram[seg_first(1, 0, 0)]     = hdr(1, 50);
            ram[seg_first(1, 0, 0) + 1] = 32'hBBBB_BBBB;
            ewc = model(fa, lst_n);
            wr_cnt = 0;
            @(negedge clk);
            drive_start(0, 0, 0, lst_n, 1);
            @(negedge clk);
            drive_start(1, 0, 0, 2, 2);
            @(negedge clk);
            start_valid = 1'b0;
            check(busy, "R9 busy during job", 32'(busy), 32'd1);
            wait_idle("R9 done");
            exp_irq = 2'b01;
            check_regs("R9 regs ignore second start");
            check(wr_cnt == ewc, "R9 writes", 32'(wr_cnt), 32'(ewc));
            check(irq_status == exp_irq, "R9 irq select", 32'(irq_status), 32'(exp_irq));
        end

        // R10: a set coinciding with a clear wins (irq bit 0 already set)
        @(negedge clk);
        drive_start(0, 0, 0, 0, 1);
        @(negedge clk);
        start_valid = 1'b0;
        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        check(!busy && irq_status == 2'b01, "R10 set wins", 32'(irq_status), 32'd1);
        clear_irq(2'b01);

        // Random jobs across all segments.
        for (int j = 0; j < 60; j++) begin
            int q = int'($urandom % 2), c = int'($urandom % 2), off = int'($urandom % 8);
            gen_random(SEGW - off);
            run_job(q, c, off, 1 + int'($urandom % 2), "R2 R4 R5 R6 R7 random");
            if ($urandom % 2 == 0) clear_irq(2'b11);
        end
        report_end();
    end
endmodule